// File: doc/BRIEF.md
# RTC Supply and Oscillator Status Register

This block is the 8-bit control and status register of a real-time clock core. It holds the supply-monitor threshold choice, a sticky under-voltage flag that turns its own monitor off, a flag that records a crystal-oscillator stop, a scratch bit, a clock-enable control bit, and three event flags that the periodic-interrupt and alarm logic next to it set. A serial front end writes the register with a one-cycle write strobe and a data byte. The register contents are always visible on `status_q` with no added latency.

Hardware events arrive as single-cycle pulses: one from the external voltage comparator, one from the oscillation-halt detector, and three from the neighbouring event logic. Software can clear each flag by writing 0 to it. Writing 1 to a flag leaves it unchanged. The monitor-enable output and the threshold select go straight to the analog comparator. All pins are plain control and status levels or strobes, so there is no back-pressure: every write strobe takes effect in the cycle it is presented.

Top module: `rtc_pwr_osc_status`

## Requirements
- R1: After reset, `status_q` is 8'h10: the oscillator-halt flag (bit 4) is 1 and every other bit is 0. `mon_en` is 1 and `thr_lo` is 0.
- R2: A write updates bit 7 (threshold select, 1 = lower level), bit 5 (scratch) and bit 3 (clock enable) to the written values. `thr_lo` always equals bit 7.
- R3: While `mon_en` is 1, a `uv_evt` pulse sets bit 6 (under-voltage flag). `mon_en` is the inverse of bit 6. While bit 6 is 1, further `uv_evt` pulses have no effect.
- R4: Writing 0 to bit 6 clears it and returns `mon_en` to 1. Writing 1 to bit 6 has no effect.
- R5: A `halt_evt` pulse sets bit 4 only while `ce_level` is 0. While `ce_level` is 1, the pulse has no effect.
- R6: Bit 4 is cleared only by writing 0 to it. Writing 1 to it has no effect.
- R7: An accepted halt event forces bit 5 to 0, even if the same cycle writes 1 to bit 5.
- R8: `pi_evt`, `alw_evt` and `ald_evt` set bits 2, 1 and 0. Writing 0 to one of these bits clears it. Writing 1 has no effect.
- R9: When a set event and a write of 0 reach the same flag (bits 4, 2, 1, 0) in one cycle, the flag ends up 1.
- R10: A write or an event presented in one cycle shows on `status_q` right after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Byte to write |
| uv_evt | input | 1 | Comparator pulse: supply seen below threshold |
| halt_evt | input | 1 | Oscillation-halt detector pulse |
| ce_level | input | 1 | Chip-enable level; high blocks halt events |
| pi_evt | input | 1 | Periodic-interrupt flag set pulse |
| alw_evt | input | 1 | Alarm W flag set pulse |
| ald_evt | input | 1 | Alarm D flag set pulse |
| status_q | output | 8 | Current register contents |
| mon_en | output | 1 | Supply monitor enable |
| thr_lo | output | 1 | Lower threshold selected |

## Verification
The hardest cases are collisions inside a single cycle: a write and a hardware event that reach the same bit at once. These are a halt pulse together with a write that clears the halt flag and sets the scratch bit, an alarm pulse together with a write that clears that alarm, and a comparator pulse together with a write that clears the under-voltage flag while the monitor is off. The bench drives the write strobe and the pulse on the same falling edge, so both reach one rising edge. It then checks the whole byte, which shows which side won for every bit.

// File: rtl/rtcst_pkg.sv
package rtcst_pkg;
  localparam int REG_W   = 8;
  localparam int B_THR   = 7;
  localparam int B_UV    = 6;
  localparam int B_SCR   = 5;
  localparam int B_HALT  = 4;
  localparam int B_CKEN  = 3;
  localparam int B_PI    = 2;
  localparam int B_ALW   = 1;
  localparam int B_ALD   = 0;
  localparam int NUM_EVT = 3;
  localparam logic [REG_W-1:0] RST_VAL = 8'h10;
endpackage

// File: rtl/rtcst_flag.sv
module rtcst_flag #(
  parameter logic RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R9: a set event beats a clear in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R4 R6 R8: only a clear request brings the flag down
  a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/rtcst_rwbit.sv
module rtcst_rwbit #(
  parameter logic RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic d_i,
  input  logic frc0_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RST;
    else if (frc0_i) q_o <= 1'b0;
    else if (wr_i)   q_o <= d_i;
  end

  // R2: a plain write lands as written
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !frc0_i) |=> (q_o == $past(d_i)));
  // R7: forcing input overrides the write
  a_r7_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frc0_i |=> !q_o);
endmodule

// File: rtl/rtc_pwr_osc_status.sv
module rtc_pwr_osc_status
  import rtcst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             uv_evt,
  input  logic             halt_evt,
  input  logic             ce_level,
  input  logic             pi_evt,
  input  logic             alw_evt,
  input  logic             ald_evt,
  output logic [REG_W-1:0] status_q,
  output logic             mon_en,
  output logic             thr_lo
);
  logic uv_q, halt_q, thr_q, scr_q, cken_q;
  logic uv_take, halt_take;
  logic [NUM_EVT-1:0] evt_in, evt_q;

  assign uv_take   = uv_evt & ~uv_q;
  assign halt_take = halt_evt & ~ce_level;

  rtcst_flag #(.RST(RST_VAL[B_UV])) u_uv (
    .clk(clk), .rst_n(rst_n), .set_i(uv_take),
    .clr_i(wr_en & ~wr_data[B_UV]), .q_o(uv_q));

  rtcst_flag #(.RST(RST_VAL[B_HALT])) u_halt (
    .clk(clk), .rst_n(rst_n), .set_i(halt_take),
    .clr_i(wr_en & ~wr_data[B_HALT]), .q_o(halt_q));

  rtcst_rwbit #(.RST(RST_VAL[B_THR])) u_thr (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .d_i(wr_data[B_THR]),
    .frc0_i(1'b0), .q_o(thr_q));

  rtcst_rwbit #(.RST(RST_VAL[B_SCR])) u_scr (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .d_i(wr_data[B_SCR]),
    .frc0_i(halt_take), .q_o(scr_q));

  rtcst_rwbit #(.RST(RST_VAL[B_CKEN])) u_cken (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .d_i(wr_data[B_CKEN]),
    .frc0_i(1'b0), .q_o(cken_q));

  assign evt_in = {pi_evt, alw_evt, ald_evt};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    rtcst_flag #(.RST(RST_VAL[B_ALD+i])) u_evt (
      .clk(clk), .rst_n(rst_n), .set_i(evt_in[i]),
      .clr_i(wr_en & ~wr_data[B_ALD+i]), .q_o(evt_q[i]));
  end

  always_comb begin
    status_q          = '0;
    status_q[B_THR]   = thr_q;
    status_q[B_UV]    = uv_q;
    status_q[B_SCR]   = scr_q;
    status_q[B_HALT]  = halt_q;
    status_q[B_CKEN]  = cken_q;
    status_q[B_ALD +: NUM_EVT] = evt_q;
  end

  assign mon_en = ~uv_q;
  assign thr_lo = thr_q;

  // R3: with the monitor off, comparator pulses cannot change the flag
  a_r3_uv_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !(wr_en && !wr_data[B_UV])) |=> status_q[B_UV]);
  // R5: a high chip enable blocks halt sensing
  a_r5_ce_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_level && !status_q[B_HALT]) |=> !status_q[B_HALT]);
  // R7: an accepted halt event leaves the scratch bit low
  a_r7_scratch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && !ce_level) |=> (status_q[B_HALT] && !status_q[B_SCR]));
  // R4: writing 0 to the under-voltage flag restarts monitoring
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[B_UV] && !mon_en) |=> mon_en);
endmodule

// File: tb/tb_rtc_pwr_osc_status.sv
module tb_rtc_pwr_osc_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic uv_evt = 1'b0, halt_evt = 1'b0, ce_level = 1'b0;
  logic pi_evt = 1'b0, alw_evt = 1'b0, ald_evt = 1'b0;
  logic [7:0] status_q;
  logic mon_en, thr_lo;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_pwr_osc_status dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .uv_evt(uv_evt), .halt_evt(halt_evt), .ce_level(ce_level),
    .pi_evt(pi_evt), .alw_evt(alw_evt), .ald_evt(ald_evt),
    .status_q(status_q), .mon_en(mon_en), .thr_lo(thr_lo));

  task automatic chk(string req, logic [7:0] exp_s, logic exp_m, logic exp_t);
    checks++;
    if (status_q !== exp_s || mon_en !== exp_m || thr_lo !== exp_t) begin
      fails++;
      $display("FAIL %s: status=%h mon_en=%b thr_lo=%b expected %h %b %b",
               req, status_q, mon_en, thr_lo, exp_s, exp_m, exp_t);
    end
  endtask

  // ev = {uv, halt, pi, alw, ald}
  task automatic step(logic we, logic [7:0] d, logic [4:0] ev);
    @(negedge clk);
    wr_en = we; wr_data = d;
    {uv_evt, halt_evt, pi_evt, alw_evt, ald_evt} = ev;
    @(posedge clk); #1;
    wr_en = 1'b0;
    {uv_evt, halt_evt, pi_evt, alw_evt, ald_evt} = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset", 8'h10, 1'b1, 1'b0);
  endtask

  task automatic t_rw;
    step(1'b1, 8'hA8, 5'b0); chk("R2 R10 write A8", 8'hA8, 1'b1, 1'b1);
    step(1'b1, 8'h00, 5'b0); chk("R2 write 00", 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'hFF, 5'b0); chk("R4 R6 R8 write ones ignored", 8'hA8, 1'b1, 1'b1);
  endtask

  task automatic t_uv;
    step(1'b0, 8'h00, 5'b10000); chk("R3 uv sets", 8'hE8, 1'b0, 1'b1);
    step(1'b0, 8'h00, 5'b10000); chk("R3 uv held", 8'hE8, 1'b0, 1'b1);
    step(1'b1, 8'hFF, 5'b0);     chk("R4 write 1 no effect", 8'hE8, 1'b0, 1'b1);
    step(1'b1, 8'hA8, 5'b10000); chk("R4 R3 clear while off", 8'hA8, 1'b1, 1'b1);
  endtask

  task automatic t_halt;
    ce_level = 1'b1;
    step(1'b0, 8'h00, 5'b01000); chk("R5 ce high blocks", 8'hA8, 1'b1, 1'b1);
    ce_level = 1'b0;
    step(1'b0, 8'h00, 5'b01000); chk("R5 R7 halt sets", 8'h98, 1'b1, 1'b1);
    step(1'b1, 8'hB8, 5'b0);     chk("R6 write 1 kept", 8'hB8, 1'b1, 1'b1);
    step(1'b1, 8'hA8, 5'b0);     chk("R6 write 0 clears", 8'hA8, 1'b1, 1'b1);
    step(1'b1, 8'hA8, 5'b01000); chk("R9 R7 halt vs write", 8'h98, 1'b1, 1'b1);
    step(1'b1, 8'hA8, 5'b0);     chk("R6 clear again", 8'hA8, 1'b1, 1'b1);
  endtask

  task automatic t_flags;
    step(1'b0, 8'h00, 5'b00100); chk("R8 pi set", 8'hAC, 1'b1, 1'b1);
    step(1'b0, 8'h00, 5'b00010); chk("R8 alw set", 8'hAE, 1'b1, 1'b1);
    step(1'b0, 8'h00, 5'b00001); chk("R8 ald set", 8'hAF, 1'b1, 1'b1);
    step(1'b1, 8'hAB, 5'b0);     chk("R8 clear pi only", 8'hAB, 1'b1, 1'b1);
    step(1'b1, 8'hA8, 5'b00010); chk("R9 alw vs write", 8'hAA, 1'b1, 1'b1);
    step(1'b1, 8'hA8, 5'b0);     chk("R8 clear all", 8'hA8, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    #1 t_reset();
    t_rw();
    t_uv();
    t_halt();
    t_flags();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule